// File: doc/BRIEF.md
# Integer Load Instruction Decoder

This block decodes a 32-bit fixed-point load instruction word. It recognises three encodings. The first adds a signed 16-bit immediate to a base register. The second adds a 14-bit immediate, scaled by four, to a base register and shares one primary opcode among three loads. The third adds an index register to a base register. For every recognised load the block reports the register numbers, the displacement and where it comes from, the access size, the signedness, the update behaviour and whether the access needs 64-bit mode.

A pipeline's decode stage feeds the block one word per cycle, with a strobe that marks the word as present. The result is held in an output register that loads only when the strobe is high, so it stays put while the stage stalls. Doubleword and signed-word loads are accepted only while the 64-bit mode input is high. Malformed encodings of a known load raise an illegal flag, which the pipeline can turn into a trap. Words that are not loads leave both flags low.

Top module: `ld_decode`

## Requirements
- R1: The primary opcode is `insn[31:26]`. The target register is `insn[25:21]` and the base register is `insn[20:16]`. For a valid load they appear on `o_rt` and `o_ra`. `o_rb` carries `insn[15:11]` for indexed loads and is zero otherwise.
- R2: The immediate-form primary opcodes set `o_size` (0=1 byte, 1=2, 2=4, 3=8), `o_signed` and `o_upd` as follows:
  - 34 and 35: byte, zero-extended.
  - 40 and 41: halfword, zero-extended.
  - 42 and 43: halfword, sign-extended.
  - 32 and 33: word, zero-extended.
  
  In each pair the odd opcode is the update form. `o_use_idx` is 0 for these opcodes.
- R3: For the immediate form, `o_disp` is `insn[15:0]` sign-extended to XLEN bits.
- R4: Primary opcode 58 uses `insn[1:0]` as a sub-opcode:
  - 00: doubleword load.
  - 01: doubleword load with update.
  - 10: signed word load.
  
  The displacement is `insn[15:2]` times four, sign-extended to XLEN bits.
- R5: Primary opcode 58 with sub-opcode 11 sets `o_illegal` and clears `o_valid`.
- R6: Primary opcode 31 is the indexed form, with the extended opcode in `insn[10:1]`. `insn[0]` is ignored. The extended opcodes are:
  - 87 and 119: byte, zero-extended.
  - 279 and 311: halfword, zero-extended.
  - 343 and 375: halfword, sign-extended.
  - 23 and 55: word, zero-extended.
  - 341 and 373: word, sign-extended.
  - 21 and 53: doubleword.
  
  In each pair the second value is the update form. Indexed loads give `o_use_idx`=1 and `o_disp`=0.
- R7: Signed-word and doubleword loads, in every form, raise `o_need64`. When `mode64` is low they set `o_illegal` and clear `o_valid` instead.
- R8: An update-form load whose base register is 0, or equals its target register, sets `o_illegal` and clears `o_valid`.
- R9: Any other word clears both `o_valid` and `o_illegal`. Whenever `o_valid` is low, every other output is zero.
- R10: The outputs update on a rising clock edge only when `in_valid` is high, and otherwise hold their value. A synchronous active-high `rst` clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word present; loads the output register |
| insn | input | 32 | Instruction word |
| mode64 | input | 1 | 64-bit mode enable |
| o_valid | output | 1 | Recognised, legal load |
| o_illegal | output | 1 | Recognised load encoding that is not allowed |
| o_rt | output | 5 | Target register number |
| o_ra | output | 5 | Base register number |
| o_rb | output | 5 | Index register number (indexed form only) |
| o_disp | output | XLEN | Sign-extended displacement |
| o_use_idx | output | 1 | Offset comes from the index register |
| o_size | output | 2 | log2 of the access size in bytes |
| o_signed | output | 1 | Loaded data is sign-extended |
| o_upd | output | 1 | Effective address is written back to the base register |
| o_need64 | output | 1 | Load needs 64-bit mode |

## Verification
The bench sweeps every primary opcode and every indexed extended opcode, in both modes, with register pairs chosen to hit a zero base and a base equal to the target.

Each fault it targets shows up differently at the outputs:
- A decoder that leaves the scaled displacement's low sub-opcode bits in place gives odd displacements on the doubleword loads.
- One that lets sub-opcode 11 through reports a signed-word update load.
- One that forgets the mode gate accepts a doubleword load in 32-bit mode.
- One that decodes `insn[0]` in the indexed form drops half of those loads.

Negative immediates catch a zero-extended displacement. Idle cycles with a changed word catch an output register that ignores the strobe.

// File: rtl/ld_decode.sv
module ld_decode #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     insn,
  input  logic            mode64,
  output logic            o_valid,
  output logic            o_illegal,
  output logic [4:0]      o_rt,
  output logic [4:0]      o_ra,
  output logic [4:0]      o_rb,
  output logic [XLEN-1:0] o_disp,
  output logic            o_use_idx,
  output logic [1:0]      o_size,
  output logic            o_signed,
  output logic            o_upd,
  output logic            o_need64
);

  localparam int EXT = XLEN - 16;

  logic [5:0] op;
  logic [9:0] xo;
  logic [4:0] rt, ra, rb;

  assign op = insn[31:26];
  assign xo = insn[10:1];
  assign rt = insn[25:21];
  assign ra = insn[20:16];
  assign rb = insn[15:11];

  logic       known, upd, sgn, idx, scaled, bad_sub;
  logic [1:0] sz;

  always_comb begin
    known   = 1'b1;
    upd     = 1'b0;
    sgn     = 1'b0;
    idx     = 1'b0;
    scaled  = 1'b0;
    bad_sub = 1'b0;
    sz      = 2'd0;
    case (op)
      6'd34: sz = 2'd0;
      6'd35: begin sz = 2'd0; upd = 1'b1; end
      6'd40: sz = 2'd1;
      6'd41: begin sz = 2'd1; upd = 1'b1; end
      6'd42: begin sz = 2'd1; sgn = 1'b1; end
      6'd43: begin sz = 2'd1; sgn = 1'b1; upd = 1'b1; end
      6'd32: sz = 2'd2;
      6'd33: begin sz = 2'd2; upd = 1'b1; end
      6'd58: begin
        scaled = 1'b1;
        case (insn[1:0])
          2'b00: sz = 2'd3;
          2'b01: begin sz = 2'd3; upd = 1'b1; end
          2'b10: begin sz = 2'd2; sgn = 1'b1; end
          default: begin sz = 2'd2; sgn = 1'b1; upd = 1'b1; bad_sub = 1'b1; end
        endcase
      end
      6'd31: begin
        idx = 1'b1;
        case (xo)
          10'd87:  sz = 2'd0;
          10'd119: begin sz = 2'd0; upd = 1'b1; end
          10'd279: sz = 2'd1;
          10'd311: begin sz = 2'd1; upd = 1'b1; end
          10'd343: begin sz = 2'd1; sgn = 1'b1; end
          10'd375: begin sz = 2'd1; sgn = 1'b1; upd = 1'b1; end
          10'd23:  sz = 2'd2;
          10'd55:  begin sz = 2'd2; upd = 1'b1; end
          10'd341: begin sz = 2'd2; sgn = 1'b1; end
          10'd373: begin sz = 2'd2; sgn = 1'b1; upd = 1'b1; end
          10'd21:  sz = 2'd3;
          10'd53:  begin sz = 2'd3; upd = 1'b1; end
          default: known = 1'b0;
        endcase
      end
      default: known = 1'b0;
    endcase
  end

  logic            need64, bad, hit;
  logic [15:0]     d16;
  logic [XLEN-1:0] disp;

  assign need64 = (sz == 2'd3) || (sz == 2'd2 && sgn);
  assign bad    = known && (bad_sub || (need64 && !mode64) ||
                            (upd && (ra == 5'd0 || ra == rt)));
  assign hit    = known && !bad;
  assign d16    = {insn[15:2], scaled ? 2'b00 : insn[1:0]};
  assign disp   = idx ? '0 : {{EXT{d16[15]}}, d16};

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid   <= 1'b0;
      o_illegal <= 1'b0;
      o_rt      <= '0;
      o_ra      <= '0;
      o_rb      <= '0;
      o_disp    <= '0;
      o_use_idx <= 1'b0;
      o_size    <= '0;
      o_signed  <= 1'b0;
      o_upd     <= 1'b0;
      o_need64  <= 1'b0;
    end else if (in_valid) begin
      o_valid   <= hit;
      o_illegal <= bad;
      o_rt      <= hit ? rt : '0;
      o_ra      <= hit ? ra : '0;
      o_rb      <= (hit && idx) ? rb : '0;
      o_disp    <= hit ? disp : '0;
      o_use_idx <= hit && idx;
      o_size    <= hit ? sz : '0;
      o_signed  <= hit && sgn;
      o_upd     <= hit && upd;
      o_need64  <= hit && need64;
    end
  end

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(o_valid && o_illegal)); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !o_valid |-> (o_rt == 0 && o_ra == 0 && o_disp == 0 && !o_upd && !o_need64)); // R9
  AST_UPD_BASE: assert property (@(posedge clk) disable iff (rst)
    (o_valid && o_upd) |-> (o_ra != 5'd0 && o_ra != o_rt)); // R8
  AST_WIDE_MODE: assert property (@(posedge clk) disable iff (rst)
    (o_valid && o_need64 && $changed(o_need64)) |-> $past(mode64)); // R7
  AST_DS_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !o_use_idx && o_size == 2'd3) |-> (o_disp[1:0] == 2'b00)); // R4
  AST_IDX_NODISP: assert property (@(posedge clk) disable iff (rst)
    o_use_idx |-> (o_disp == 0)); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(o_valid) && $stable(o_illegal) && $stable(o_disp))); // R10

endmodule

// File: tb/ld_decode_test.sv
module ld_decode_test;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [31:0]     insn = '0;
  logic            mode64 = 1'b0;
  logic            o_valid, o_illegal, o_use_idx, o_signed, o_upd, o_need64;
  logic [4:0]      o_rt, o_ra, o_rb;
  logic [XLEN-1:0] o_disp;
  logic [1:0]      o_size;

  int vectors = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  ld_decode #(.XLEN(XLEN)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn), .mode64(mode64),
    .o_valid(o_valid), .o_illegal(o_illegal), .o_rt(o_rt), .o_ra(o_ra),
    .o_rb(o_rb), .o_disp(o_disp), .o_use_idx(o_use_idx), .o_size(o_size),
    .o_signed(o_signed), .o_upd(o_upd), .o_need64(o_need64)
  );

  logic            e_valid, e_illegal, e_idx, e_sgn, e_upd, e_w64;
  logic [4:0]      e_rt, e_ra, e_rb;
  logic [XLEN-1:0] e_disp;
  logic [1:0]      e_size;
  string           flag_req, disp_req, kind_req;

  task automatic chk(input string req, input string what,
                     input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s insn=%h mode64=%0b actual=%h expected=%h",
               req, what, insn, mode64, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] w, input logic m64);
    logic       k, u, s, x, b3;
    logic [1:0] z;
    logic [5:0] p;
    logic [9:0] e;
    int         dd;
    p = w[31:26];
    e = w[10:1];
    k = 1'b0; u = 1'b0; s = 1'b0; x = 1'b0; b3 = 1'b0; z = 2'd0;
    dd = 0;
    flag_req = "R9"; disp_req = "R3"; kind_req = "R2";
    if (p >= 32 && p <= 43 && !(p >= 36 && p <= 39)) begin
      k = 1'b1;
      u = p[0];
      case ({p[5:1], 1'b0})
        6'd34: z = 2'd0;
        6'd40: z = 2'd1;
        6'd42: begin z = 2'd1; s = 1'b1; end
        default: z = 2'd2;
      endcase
      dd = $signed(w[15:0]);
    end else if (p == 6'd58) begin
      k = 1'b1;
      kind_req = "R4"; disp_req = "R4";
      u = w[0];
      b3 = (w[1:0] == 2'b11);
      if (w[1]) begin z = 2'd2; s = 1'b1; end else z = 2'd3;
      dd = $signed(w[15:2]) * 4;
    end else if (p == 6'd31) begin
      kind_req = "R6"; disp_req = "R6";
      x = 1'b1;
      u = e[5];
      k = 1'b1;
      case (e & ~10'd32)
        10'd87:  z = 2'd0;
        10'd279: z = 2'd1;
        10'd343: begin z = 2'd1; s = 1'b1; end
        10'd23:  z = 2'd2;
        10'd341: begin z = 2'd2; s = 1'b1; end
        10'd21:  z = 2'd3;
        default: k = 1'b0;
      endcase
    end
    e_w64 = k && ((z == 2'd3) || (z == 2'd2 && s));
    e_illegal = 1'b0;
    if (k) begin
      if (b3) begin e_illegal = 1'b1; flag_req = "R5"; end
      else if (e_w64 && !m64) begin e_illegal = 1'b1; flag_req = "R7"; end
      else if (u && (w[20:16] == 0 || w[20:16] == w[25:21])) begin
        e_illegal = 1'b1; flag_req = "R8";
      end else flag_req = kind_req;
    end
    e_valid = k && !e_illegal;
    e_rt   = e_valid ? w[25:21] : 5'd0;
    e_ra   = e_valid ? w[20:16] : 5'd0;
    e_rb   = (e_valid && x) ? w[15:11] : 5'd0;
    e_idx  = e_valid && x;
    e_disp = (e_valid && !x) ? XLEN'(signed'(dd)) : '0;
    e_size = e_valid ? z : 2'd0;
    e_sgn  = e_valid && s;
    e_upd  = e_valid && u;
    e_w64  = e_valid && e_w64;
  endtask

  task automatic compare_all();
    chk(flag_req, "valid",   XLEN'(o_valid),   XLEN'(e_valid));
    chk(flag_req, "illegal", XLEN'(o_illegal), XLEN'(e_illegal));
    chk("R1", "rt", XLEN'(o_rt), XLEN'(e_rt));
    chk("R1", "ra", XLEN'(o_ra), XLEN'(e_ra));
    chk("R1", "rb", XLEN'(o_rb), XLEN'(e_rb));
    chk(disp_req, "disp", o_disp, e_disp);
    chk(kind_req, "use_idx", XLEN'(o_use_idx), XLEN'(e_idx));
    chk(kind_req, "size",    XLEN'(o_size),    XLEN'(e_size));
    chk(kind_req, "signed",  XLEN'(o_signed),  XLEN'(e_sgn));
    chk(kind_req, "upd",     XLEN'(o_upd),     XLEN'(e_upd));
    chk("R7", "need64",      XLEN'(o_need64),  XLEN'(e_w64));
  endtask

  task automatic apply(input logic [31:0] w, input logic m64);
    @(negedge clk);
    insn = w; mode64 = m64; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    model(w, m64);
    vectors++;
    compare_all();
  endtask

  function automatic logic [31:0] mk(input logic [5:0] p, input int k, input logic [25:0] seed);
    logic [4:0]  t, a;
    logic [15:0] lo;
    t  = 5'(k * 5 + 3);
    a  = (k == 0) ? 5'd0 : (k == 1) ? t : 5'(k * 7 + 1);
    lo = seed[15:0] ^ 16'(k * 16'h2493);
    lo[15] = k[1];
    lo[1:0] = 2'(k);
    return {p, t, a, lo};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    model(32'h0, 1'b0);
    chk("R10", "reset valid",   XLEN'(o_valid),   '0);
    chk("R10", "reset illegal", XLEN'(o_illegal), '0);
    chk("R10", "reset disp",    o_disp,           '0);
    vectors++;
    rst = 1'b0;

    for (int p = 0; p < 64; p++)
      for (int m = 0; m < 2; m++)
        for (int k = 0; k < 8; k++)
          apply(mk(6'(p), k, 26'(p * 977 + 12345)), m[0]);

    for (int x = 0; x < 1024; x++)
      for (int m = 0; m < 2; m++)
        for (int k = 0; k < 4; k++) begin
          logic [31:0] w;
          w = mk(6'd31, k, 26'(x * 31));
          w[10:1] = 10'(x);
          w[0] = k[0];
          apply(w, m[0]);
        end

    apply(32'hE8A5_8004, 1'b1);
    @(negedge clk);
    insn = 32'h8800_0000; in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    model(32'hE8A5_8004, 1'b1);
    kind_req = "R10"; disp_req = "R10"; flag_req = "R10";
    vectors++;
    compare_all();

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10", "sync reset valid", XLEN'(o_valid), '0);
    chk("R10", "sync reset disp",  o_disp,         '0);
    vectors++;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule